// File: doc/BRIEF.md
# Transmitter Fail-Safe Supervisor

This block sits between a controller's serial transmit line and the enable of a bus line driver. In normal operation a low (dominant) transmit bit turns the driver on and a high (recessive) bit leaves the bus released. Around that path it applies the safety rules of a bus transceiver. A transmit line stuck low is cut off after a programmable number of clock cycles. A thermal fault removes drive at once. Two supply-fault levels push the block into a quieter operating state.

Both the timeout and the thermal interlock release only after the transmit line has been seen high. This stops a stuck-low controller or a die near its thermal limit from toggling the driver. The low supply level selects standby and overrides the standby request pin. The lower switch-off level turns the block off and asserts a bus-disengage output. The analog detectors arrive as synchronous digital flags.

Top module: `tx_failsafe_guard`

## Requirements
- R1: After reset, `mode` is STANDBY (2'b01), `drv_en` is 0 and `bus_off` is 0.
- R2: With no supply fault, `mode` becomes NORMAL (2'b00) one clock edge after `stb_req` is sampled 0, and STANDBY (2'b01) one edge after it is sampled 1.
- R3: In NORMAL with no fault or lock active, `drv_en` equals the inverse of `txd` in the same cycle (txd 0 = dominant = drive).
- R4: When `txd` is sampled 0 on DOM_TIMEOUT consecutive rising edges, `drv_en` is 0 after the last of those edges. After DOM_TIMEOUT-1 such edges it is still 1.
- R5: Once the timeout has tripped, `drv_en` stays 0 while `txd` is low. It may drive again only after `txd` has been sampled 1 on a rising edge.
- R6: While `ovt` is 1, `drv_en` is 0 in the same cycle.
- R7: After `ovt` returns to 0, `drv_en` stays 0 until `txd` has been sampled 1 on a rising edge with `ovt` at 0.
- R8: While `uv_stby` is 1 and `uv_off` is 0, `mode` is STANDBY from the next edge on, whatever `stb_req` is. When the flag clears, the pin request takes effect again.
- R9: While `uv_off` is 1, `mode` is OFF (2'b10) and `bus_off` is 1 from the next edge on. This takes precedence over `uv_stby`. When the flag clears, the block leaves OFF.
- R10: In STANDBY or OFF, `drv_en` is 0 for any value of `txd`.
- R11: Sampling `txd` high on a single edge restarts the dominant timer, so two low runs of DOM_TIMEOUT-1 edges separated by one high edge do not trip it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| txd | input | 1 | Transmit data, 0 = dominant |
| stb_req | input | 1 | Standby request, 1 = standby |
| ovt | input | 1 | Overtemperature flag |
| uv_stby | input | 1 | Standby-level undervoltage flag |
| uv_off | input | 1 | Switch-off undervoltage flag |
| drv_en | output | 1 | Bus driver enable (drive dominant) |
| mode | output | 2 | Effective mode: 00 normal, 01 standby, 10 off |
| bus_off | output | 1 | Disengage from bus |

## Verification
The bench probes the timeout boundary on both sides: one edge short of the limit, and exactly at it. A counter off by one would cut the driver a cycle early or late. It interrupts a low run with a single high edge to catch a timer that never restarts, which would trip falsely on the second run. It clears the thermal flag while the transmit line is still low; a design without the interlock would drive again straight away. It raises both supply flags together and toggles the standby pin during a supply fault, exposing wrong fault priority or a pin request that leaks through.

// File: rtl/tx_failsafe_guard.sv
module tx_failsafe_guard #(
  parameter int DOM_TIMEOUT = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txd,
  input  logic       stb_req,
  input  logic       ovt,
  input  logic       uv_stby,
  input  logic       uv_off,
  output logic       drv_en,
  output logic [1:0] mode,
  output logic       bus_off
);

  localparam int CW = $clog2(DOM_TIMEOUT + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DOM_TIMEOUT - 1);
  localparam logic [1:0] M_NORM = 2'b00;
  localparam logic [1:0] M_STBY = 2'b01;
  localparam logic [1:0] M_OFF  = 2'b10;

  logic [CW-1:0] dom_cnt;
  logic          dom_trip;
  logic          hot_lock;
  logic [1:0]    mode_q;
  logic [1:0]    mode_d;

  always_comb begin
    if (uv_off)       mode_d = M_OFF;
    else if (uv_stby) mode_d = M_STBY;
    else if (stb_req) mode_d = M_STBY;
    else              mode_d = M_NORM;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= M_STBY;
    else        mode_q <= mode_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dom_cnt  <= '0;
      dom_trip <= 1'b0;
    end else if (txd) begin
      dom_cnt  <= '0;
      dom_trip <= 1'b0;
    end else begin
      if (dom_cnt == LIMIT) dom_trip <= 1'b1;
      if (!dom_trip) dom_cnt <= dom_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          hot_lock <= 1'b0;
    else if (ovt)        hot_lock <= 1'b1;
    else if (txd)        hot_lock <= 1'b0;
  end

  assign mode    = mode_q;
  assign bus_off = (mode_q == M_OFF);
  assign drv_en  = (mode_q == M_NORM) & ~txd & ~dom_trip & ~hot_lock & ~ovt;

  // R9
  uv_off_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
    uv_off |=> (mode == M_OFF) && bus_off);

  // R8
  uv_stby_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv_off && uv_stby) |=> (mode == M_STBY));

  // R2
  pin_normal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!uv_off && !uv_stby && !stb_req) |=> (mode == M_NORM));

  // R7
  hot_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovt ##1 (!ovt && !txd)) |-> !drv_en);

  // R4
  dom_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((!txd && dom_cnt == LIMIT) ##1 !txd) |-> !drv_en);

  // R10
  quiet_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != M_NORM) |-> !drv_en);

endmodule

// File: tb/tx_failsafe_guard_test.sv
`timescale 1ns/1ps
module tx_failsafe_guard_test;
  localparam int T = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic txd = 1'b1, stb_req = 1'b1, ovt = 1'b0, uv_stby = 1'b0, uv_off = 1'b0;
  logic drv_en, bus_off;
  logic [1:0] mode;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tx_failsafe_guard #(.DOM_TIMEOUT(T)) uut (
    .clk(clk), .rst_n(rst_n), .txd(txd), .stb_req(stb_req), .ovt(ovt),
    .uv_stby(uv_stby), .uv_off(uv_off), .drv_en(drv_en), .mode(mode),
    .bus_off(bus_off));

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic settle();
    #0.5;
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
  endtask

  task automatic t_reset();
    chk("R1 mode", mode, 1);
    chk("R1 drv_en", drv_en, 0);
    chk("R1 bus_off", bus_off, 0);
    txd = 0; settle();
    chk("R10 standby no drive", drv_en, 0);
    txd = 1;
  endtask

  task automatic t_normal();
    stb_req = 0; tick(1);
    chk("R2 normal", mode, 0);
    txd = 0; settle();
    chk("R3 dominant", drv_en, 1);
    txd = 1; settle();
    chk("R3 recessive", drv_en, 0);
    stb_req = 1; tick(1);
    chk("R2 standby", mode, 1);
    stb_req = 0; tick(1);
  endtask

  task automatic t_timer_restart();
    txd = 0; tick(T - 1);
    txd = 1; tick(1);
    txd = 0; tick(T - 1);
    chk("R11 no trip", drv_en, 1);
    txd = 1; tick(1);
  endtask

  task automatic t_timeout();
    txd = 0; tick(T - 1);
    chk("R4 before limit", drv_en, 1);
    tick(1);
    chk("R4 at limit", drv_en, 0);
    tick(5);
    chk("R5 held off", drv_en, 0);
    txd = 1; tick(1);
    txd = 0; settle();
    chk("R5 released", drv_en, 1);
    txd = 1; tick(1);
  endtask

  task automatic t_overtemp();
    txd = 0; settle();
    chk("R3 pre ovt", drv_en, 1);
    ovt = 1; settle();
    chk("R6 immediate", drv_en, 0);
    tick(3);
    ovt = 0; tick(2);
    chk("R7 interlock", drv_en, 0);
    txd = 1; tick(1);
    txd = 0; settle();
    chk("R7 released", drv_en, 1);
    txd = 1; tick(1);
  endtask

  task automatic t_uv_stby();
    uv_stby = 1; stb_req = 0; tick(1);
    chk("R8 forced standby", mode, 1);
    txd = 0; settle();
    chk("R10 uv standby no drive", drv_en, 0);
    txd = 1; stb_req = 1; tick(1);
    stb_req = 0; tick(1);
    chk("R8 pin ignored", mode, 1);
    uv_stby = 0; tick(1);
    chk("R8 recovered", mode, 0);
  endtask

  task automatic t_uv_off();
    uv_off = 1; uv_stby = 1; tick(1);
    chk("R9 off mode", mode, 2);
    chk("R9 bus_off", bus_off, 1);
    txd = 0; settle();
    chk("R10 off no drive", drv_en, 0);
    txd = 1; uv_off = 0; tick(1);
    chk("R9 to standby", mode, 1);
    chk("R9 bus_off clear", bus_off, 0);
    uv_stby = 0; tick(1);
    chk("R9 back normal", mode, 0);
  endtask

  initial begin
    #100000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got 1 expected 0");
      summary();
      $finish;
    end
  end

  initial begin
    tick(2);
    rst_n = 1'b1;
    tick(1);
    t_reset();
    t_normal();
    t_timer_restart();
    t_timeout();
    t_overtemp();
    t_uv_stby();
    t_uv_off();
    done = 1;
    summary();
    $finish;
  end
endmodule